// File: doc/BRIEF.md
# One-Hot Control Sequencer with Single-Upset Trap

This block is a five-state synchronous controller whose state lives in a one-hot register. It steps through a fixed handshake loop and raises one control enable per state. The states are IDLE, FETCH, PROCESS and SEND, plus a trap state, ERROR.

The transitions are:
- IDLE to FETCH on `start`
- FETCH to PROCESS on `data_valid`
- PROCESS to SEND on `done`
- SEND back to IDLE on `ack`
- ERROR to IDLE on `clear`

Every state holds while its own condition is low.

An XOR reduction over the state flops checks the register's integrity on every cycle. A legal code has exactly one bit high, so its parity is odd. A single flipped bit leaves either zero or two bits high, so its parity is even. An even result raises `parity_fail`. On the next edge, a multiplexer in front of the register then loads the ERROR code in place of the normal next state. This does not depend on any default branch in the decode.

For test, an XOR mask can be applied to the register on any chosen edge. This models a particle-induced upset. All inputs must already be synchronous to `clk`.

Top module: `seu_onehot_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `state_vec` is 5'b00001 (IDLE, bit 0), `idle_en` is 1, `error_flag` is 0 and `parity_fail` is 0.
- R2: From IDLE (5'b00001), `start` high moves the state to FETCH (5'b00010) on the next edge. With `start` low, the state stays in IDLE.
- R3: From FETCH, `data_valid` high moves the state to PROCESS (5'b00100) on the next edge. Otherwise the state stays in FETCH.
- R4: From PROCESS, `done` high moves the state to SEND (5'b01000) on the next edge. Otherwise the state stays in PROCESS.
- R5: From SEND, `ack` high moves the state to IDLE on the next edge. Otherwise the state stays in SEND.
- R6: `parity_fail` is combinational. It is 1 exactly when `state_vec` holds an even number of ones, which includes zero.
- R7: On any edge where `parity_fail` is 1 and `inj_en` is 0, the state becomes ERROR (5'b10000), whatever the handshake inputs are.
- R8: On an edge where `inj_en` is 1, the state becomes the previous `state_vec` XOR `inj_mask`. No transition is taken on that edge.
- R9: `error_flag` is a registered output. It is 1 exactly while `state_vec` equals 5'b10000.
- R10: In ERROR, `clear` high returns the state to IDLE on the next edge. With `clear` low, the state holds, and `start`, `data_valid`, `done` and `ack` have no effect.
- R11: Each control enable equals its own state bit: `idle_en` is bit 0, `fetch_en` is bit 1, `proc_en` is bit 2 and `send_en` is bit 3. No enable is high in ERROR.
- R12: Any single-bit mask injected into any legal state yields `parity_fail` = 1 in the following cycle, and then ERROR one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to IDLE |
| start | input | 1 | Request to leave IDLE |
| data_valid | input | 1 | Fetched data is ready |
| done | input | 1 | Processing has finished |
| ack | input | 1 | Transmission acknowledged |
| clear | input | 1 | Leave ERROR and return to IDLE |
| inj_en | input | 1 | Test: apply `inj_mask` to the state on this edge |
| inj_mask | input | 5 | Test: bits to flip in the state register |
| idle_en | output | 1 | High in IDLE |
| fetch_en | output | 1 | High in FETCH |
| proc_en | output | 1 | High in PROCESS |
| send_en | output | 1 | High in SEND |
| error_flag | output | 1 | Registered; high while in ERROR |
| parity_fail | output | 1 | Combinational integrity alarm on the current state |
| state_vec | output | 5 | Raw one-hot state register |

## Verification
The timing of each result is as follows:
- A handshake, a `clear` or an injection changes `state_vec`, the enables and `error_flag` one edge after it is driven.
- `parity_fail` follows the register in the same cycle, so an injected upset shows up one edge after `inj_en`.
- The trap into ERROR lands on the edge after that, so two edges after the injection.

The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next rising edge. For an upset, it checks `parity_fail` after the injection edge and checks ERROR one edge later. It never samples at the edge itself.

// File: rtl/seu_fsm_pkg.sv
package seu_fsm_pkg;
    localparam int NUM_ST = 5;
    localparam int IDX_W  = $clog2(NUM_ST);

    typedef enum logic [IDX_W-1:0] {
        ST_IDLE = 3'd0,
        ST_GET  = 3'd1,
        ST_PROC = 3'd2,
        ST_SEND = 3'd3,
        ST_ERR  = 3'd4
    } st_idx_e;

    typedef logic [NUM_ST-1:0] st_vec_t;

    function automatic st_vec_t code_of(st_idx_e s);
        st_vec_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/onehot_parity.sv
module onehot_parity #(
    parameter int W = 5
) (
    input  logic [W-1:0] vec,
    output logic         fail
);
    logic [W-1:0] chain;

    assign chain[0] = vec[0];
    generate
        for (genvar i = 1; i < W; i++) begin : g_xor
            assign chain[i] = chain[i-1] ^ vec[i];
        end
    endgenerate

    // A legal one-hot code has odd parity; even parity marks an upset.
    assign fail = ~chain[W-1];
endmodule

// File: rtl/seu_next_state.sv
module seu_next_state
    import seu_fsm_pkg::*;
(
    input  st_vec_t st_q,
    input  logic    start,
    input  logic    data_valid,
    input  logic    done,
    input  logic    ack,
    input  logic    clear,
    output st_vec_t nxt_norm
);
    st_idx_e cur;

    // Lowest set bit names the state; the result is only used when parity is good.
    always_comb begin
        cur = ST_IDLE;
        for (int i = NUM_ST - 1; i >= 0; i--) begin
            if (st_q[i]) cur = st_idx_e'(i[IDX_W-1:0]);
        end
    end

    always_comb begin
        nxt_norm = st_q;
        unique case (cur)
            ST_IDLE: if (start)      nxt_norm = code_of(ST_GET);
            ST_GET:  if (data_valid) nxt_norm = code_of(ST_PROC);
            ST_PROC: if (done)       nxt_norm = code_of(ST_SEND);
            ST_SEND: if (ack)        nxt_norm = code_of(ST_IDLE);
            ST_ERR:  if (clear)      nxt_norm = code_of(ST_IDLE);
            default:                 nxt_norm = code_of(ST_ERR);
        endcase
    end
endmodule

// File: rtl/seu_state_reg.sv
module seu_state_reg
    import seu_fsm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  st_vec_t nxt_norm,
    input  logic    fail,
    input  logic    inj_en,
    input  st_vec_t inj_mask,
    output st_vec_t st_q,
    output logic    err_q
);
    st_vec_t nxt_sel;

    // Injection wins, then the trap multiplexer, then the normal next state.
    always_comb begin
        if (inj_en)    nxt_sel = st_q ^ inj_mask;
        else if (fail) nxt_sel = code_of(ST_ERR);
        else           nxt_sel = nxt_norm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= code_of(ST_IDLE);
            err_q <= 1'b0;
        end else begin
            st_q  <= nxt_sel;
            err_q <= (nxt_sel == code_of(ST_ERR));
        end
    end

    p_inject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |=> st_q == ($past(st_q) ^ $past(inj_mask)));

    p_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !inj_en) |=> st_q == code_of(ST_ERR));
endmodule

// File: rtl/seu_onehot_ctrl.sv
module seu_onehot_ctrl
    import seu_fsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              data_valid,
    input  logic              done,
    input  logic              ack,
    input  logic              clear,
    input  logic              inj_en,
    input  logic [NUM_ST-1:0] inj_mask,
    output logic              idle_en,
    output logic              fetch_en,
    output logic              proc_en,
    output logic              send_en,
    output logic              error_flag,
    output logic              parity_fail,
    output logic [NUM_ST-1:0] state_vec
);
    st_vec_t st_q;
    st_vec_t nxt_norm;
    logic    fail;
    logic    err_q;

    onehot_parity #(.W(NUM_ST)) u_parity (
        .vec  (st_q),
        .fail (fail)
    );

    seu_next_state u_next (
        .st_q       (st_q),
        .start      (start),
        .data_valid (data_valid),
        .done       (done),
        .ack        (ack),
        .clear      (clear),
        .nxt_norm   (nxt_norm)
    );

    seu_state_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_norm (nxt_norm),
        .fail     (fail),
        .inj_en   (inj_en),
        .inj_mask (inj_mask),
        .st_q     (st_q),
        .err_q    (err_q)
    );

    // Each enable comes straight from one flop bit.
    always_comb begin
        idle_en     = st_q[ST_IDLE];
        fetch_en    = st_q[ST_GET];
        proc_en     = st_q[ST_PROC];
        send_en     = st_q[ST_SEND];
        error_flag  = err_q;
        parity_fail = fail;
        state_vec   = st_q;
    end

    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        parity_fail == ($countones(state_vec) % 2 == 0));

    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error_flag == (state_vec == code_of(ST_ERR)));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vec == code_of(ST_IDLE) && start && !inj_en) |=> state_vec == code_of(ST_GET));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vec == code_of(ST_ERR) && clear && !inj_en) |=> state_vec == code_of(ST_IDLE));

    p_enables_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_fail |-> $onehot0({idle_en, fetch_en, proc_en, send_en}));
endmodule

// File: tb/seu_onehot_ctrl_bench.sv
`timescale 1ns/1ps
module seu_onehot_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 0, data_valid = 0, done = 0, ack = 0, clear = 0, inj_en = 0;
    logic [4:0] inj_mask = '0;
    logic       idle_en, fetch_en, proc_en, send_en, error_flag, parity_fail;
    logic [4:0] state_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    localparam logic [4:0] C_IDLE = 5'b00001, C_GET = 5'b00010, C_PROC = 5'b00100,
                           C_SEND = 5'b01000, C_ERR = 5'b10000;

    always #2 clk = ~clk;

    seu_onehot_ctrl u_seu_onehot_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .data_valid(data_valid), .done(done),
        .ack(ack), .clear(clear), .inj_en(inj_en), .inj_mask(inj_mask),
        .idle_en(idle_en), .fetch_en(fetch_en), .proc_en(proc_en), .send_en(send_en),
        .error_flag(error_flag), .parity_fail(parity_fail), .state_vec(state_vec)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(logic s, logic dv, logic dn, logic ak, logic cl);
        start = s; data_valid = dv; done = dn; ack = ak; clear = cl;
        inj_en = 0; inj_mask = '0;
    endtask

    // One edge, then sample 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic goto_state(logic [4:0] tgt);
        if (tgt == C_IDLE) return;
        drive(1, 0, 0, 0, 0); tick();
        if (tgt == C_GET) return;
        drive(0, 1, 0, 0, 0); tick();
        if (tgt == C_PROC) return;
        drive(0, 0, 1, 0, 0); tick();
    endtask

    task automatic do_reset();
        rst_n = 0;
        drive(0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1;
        @(posedge clk);
        #1;
    endtask

    task automatic check_enables(string req, logic [4:0] st);
        chk(req, {4'd0, idle_en, fetch_en, proc_en, send_en},
            {4'd0, st[0], st[1], st[2], st[3]});
    endtask

    task automatic t_reset();
        rst_n = 0;
        #3;
        chk("R1 state in reset", {3'd0, state_vec}, {3'd0, C_IDLE});
        do_reset();
        chk("R1 state", {3'd0, state_vec}, {3'd0, C_IDLE});
        chk("R1 idle_en", {7'd0, idle_en}, 8'd1);
        chk("R1 error_flag", {7'd0, error_flag}, 8'd0);
        chk("R1 parity_fail", {7'd0, parity_fail}, 8'd0);
    endtask

    task automatic t_loop();
        do_reset();
        drive(0, 1, 1, 1, 1); tick();
        chk("R2 idle hold", {3'd0, state_vec}, {3'd0, C_IDLE});
        drive(1, 0, 0, 0, 0); tick();
        chk("R2 to fetch", {3'd0, state_vec}, {3'd0, C_GET});
        check_enables("R11 fetch", C_GET);
        drive(1, 0, 1, 1, 0); tick();
        chk("R3 fetch hold", {3'd0, state_vec}, {3'd0, C_GET});
        drive(0, 1, 0, 0, 0); tick();
        chk("R3 to process", {3'd0, state_vec}, {3'd0, C_PROC});
        check_enables("R11 process", C_PROC);
        drive(1, 1, 0, 1, 0); tick();
        chk("R4 process hold", {3'd0, state_vec}, {3'd0, C_PROC});
        drive(0, 0, 1, 0, 0); tick();
        chk("R4 to send", {3'd0, state_vec}, {3'd0, C_SEND});
        check_enables("R11 send", C_SEND);
        drive(1, 1, 1, 0, 0); tick();
        chk("R5 send hold", {3'd0, state_vec}, {3'd0, C_SEND});
        drive(0, 0, 0, 1, 0); tick();
        chk("R5 to idle", {3'd0, state_vec}, {3'd0, C_IDLE});
        check_enables("R11 idle", C_IDLE);
        chk("R6 legal parity", {7'd0, parity_fail}, 8'd0);
    endtask

    task automatic t_single_flips();
        logic [4:0] legal [4] = '{C_IDLE, C_GET, C_PROC, C_SEND};
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 5; b++) begin
                do_reset();
                goto_state(legal[s]);
                drive(1, 1, 1, 1, 0);
                inj_en = 1; inj_mask = 5'b1 << b;
                tick();
                chk("R8 injected value", {3'd0, state_vec}, {3'd0, legal[s] ^ (5'b1 << b)});
                chk("R12 single flip caught", {7'd0, parity_fail}, 8'd1);
                chk("R9 flag low before trap", {7'd0, error_flag}, 8'd0);
                drive(1, 1, 1, 1, 0); tick();
                chk("R7 trapped", {3'd0, state_vec}, {3'd0, C_ERR});
                chk("R9 flag in error", {7'd0, error_flag}, 8'd1);
                check_enables("R11 error", C_ERR);
            end
        end
    endtask

    task automatic t_error_hold_clear();
        do_reset();
        drive(0, 0, 0, 0, 0); inj_en = 1; inj_mask = C_IDLE; tick();
        chk("R6 zero vector", {7'd0, parity_fail}, 8'd1);
        tick();
        chk("R7 zero trapped", {3'd0, state_vec}, {3'd0, C_ERR});
        drive(1, 1, 1, 1, 0); tick();
        chk("R10 hold in error", {3'd0, state_vec}, {3'd0, C_ERR});
        chk("R10 flag held", {7'd0, error_flag}, 8'd1);
        drive(0, 0, 0, 0, 1); tick();
        chk("R10 clear to idle", {3'd0, state_vec}, {3'd0, C_IDLE});
        chk("R9 flag cleared", {7'd0, error_flag}, 8'd0);
        drive(1, 0, 0, 0, 0); tick();
        chk("R2 run after clear", {3'd0, state_vec}, {3'd0, C_GET});
    endtask

    task automatic t_error_upset();
        do_reset();
        drive(0, 0, 0, 0, 0); inj_en = 1; inj_mask = 5'b00110; tick();
        chk("R6 three ones odd", {7'd0, parity_fail}, 8'd0);
        chk("R8 multi mask", {3'd0, state_vec}, {3'd0, 5'b00111});
        do_reset();
        drive(0, 0, 0, 0, 0); inj_en = 1; inj_mask = C_IDLE; tick();
        tick();
        drive(0, 0, 0, 0, 1); inj_en = 1; inj_mask = 5'b00001; tick();
        chk("R8 flip in error", {3'd0, state_vec}, {3'd0, 5'b10001});
        chk("R9 flag off upset", {7'd0, error_flag}, 8'd0);
        drive(0, 0, 0, 0, 1); tick();
        chk("R7 retrap despite clear", {3'd0, state_vec}, {3'd0, C_ERR});
    endtask

    initial begin
        t_reset();
        t_loop();
        t_single_flips();
        t_error_hold_clear();
        t_error_upset();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule